// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block sits between the processors of a cacheless system and their shared memory and enforces load-locked / store-conditional semantics. Each requester is an execution context, named by a CPU number and a thread number. A locked read places a reservation on the 16-byte granule of its address. A store-conditional writes memory only while its own context still holds a reservation on that granule. Every write that reaches the block clears the reservations it touches, whatever their owner.

The table keeps at most one reservation per context. A context that issues a new locked read moves its reservation to the new granule. Different contexts may reserve the same granule at once. When a locked read needs a new entry and the table is full, the entry that was allocated longest ago is replaced. Moving an existing reservation does not change its age. The gate (`wr_en`) and the conditional result (`sc_ok`) are combinational in the request cycle. The table updates on the following clock edge.

Top module: `resv_monitor`

## Requirements
- R1: After reset the table is empty. A store-conditional to any address gives wr_en=0 and sc_ok=0, and an ordinary store gives wr_en=1.
- R2: Addresses are compared on bits [ADDR_W-1:4]. A reservation covers every address in its 16-byte granule and no address in the next granule.
- R3: A locked read from a context that already holds a reservation moves that reservation to the new granule. The old granule is then no longer reserved for that context.
- R4: A store-conditional (req_write=1, req_locked=1) succeeds only when an entry with the same granule and the same CPU and thread number is valid. Success gives sc_ok=1 and wr_en=1, and the reservation is consumed.
- R5: Every write clears all entries on its granule, for every owning context. This holds for an ordinary store, a successful store-conditional and a failed store-conditional.
- R6: An ordinary store (req_write=1, req_locked=0) always gives wr_en=1 and sc_ok=0.
- R7: A failed store-conditional gives wr_en=0 and sc_ok=0.
- R8: Several contexts may reserve the same granule at once. The first of them to store-conditional succeeds, and the others then fail.
- R9: When the table is full and a locked read comes from a context with no entry, the entry allocated earliest is overwritten. Moving a reservation under R3 does not make it younger. The evicted context's next store-conditional fails, and the other contexts keep their reservations.
- R10: A plain read (req_write=0, req_locked=0), and any cycle with req_valid=0, leave the table unchanged.
- R11: wr_en and sc_ok are 0 in every cycle that does not carry a valid write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Locked read or conditional store |
| req_addr | input | ADDR_W | Physical byte address |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thread | input | THR_W | Thread number within that CPU |
| wr_en | output | 1 | Memory write permitted for this request |
| sc_ok | output | 1 | Store-conditional success |

## Verification
The assertions assume a single request per cycle, with inputs held stable across the sampling edge. They also assume that the CPU and thread fields together name each context uniquely. The bench drives every request at the falling edge and compares the outputs one time step later against a behavioural table kept by allocation timestamp. That table is updated only after the check. Granules are confined to a few nearby blocks and offsets cover all 16 byte positions, so boundary hits, shared granules and full-table evictions occur often. Eight contexts compete for four entries.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [2:0] {
        RK_IDLE,
        RK_READ,
        RK_LL,
        RK_STORE,
        RK_SC
    } req_kind_e;

    function automatic req_kind_e classify(input logic v, input logic w, input logic l);
        if (!v)     return RK_IDLE;
        if (w && l) return RK_SC;
        if (w)      return RK_STORE;
        if (l)      return RK_LL;
        return RK_READ;
    endfunction

endpackage

// File: rtl/resv_cmp.sv
module resv_cmp #(
    parameter int ENTRIES = 4,
    parameter int GW      = 28,
    parameter int CTX_W   = 3
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][GW-1:0]    gran,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ctx,
    input  logic [GW-1:0]                 req_gran,
    input  logic [CTX_W-1:0]              req_ctx,
    output logic [ENTRIES-1:0]            addr_hit,
    output logic [ENTRIES-1:0]            ctx_hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_lane
        assign addr_hit[i] = valid[i] && (gran[i] == req_gran);
        assign ctx_hit[i]  = valid[i] && (ctx[i] == req_ctx);
    end
endmodule

// File: rtl/resv_age.sv
module resv_age #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               alloc_en,
    input  logic [IDX_W-1:0]   alloc_idx,
    output logic [ENTRIES-1:0] oldest
);
    // older[i][j] = 1 : entry i was allocated before entry j
    typedef struct packed {
        logic [ENTRIES-1:0][ENTRIES-1:0] older;
    } age_t;

    age_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (alloc_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (IDX_W'(j) != alloc_idx) begin
                    age_d.older[alloc_idx][j] = 1'b0;
                    age_d.older[j][alloc_idx] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            oldest[i] = valid[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && valid[j] && !age_q.older[i][j]) oldest[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_OLDEST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid) |-> ($countones(oldest) == 1)); // R9

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4,
    parameter int CPU_W     = 2,
    parameter int THR_W     = 1,
    parameter int ENTRIES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thread,
    output logic              wr_en,
    output logic              sc_ok
);
    localparam int GW    = ADDR_W - GRAN_BITS;
    localparam int CTX_W = CPU_W + THR_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][GW-1:0]    gran;
        logic [ENTRIES-1:0][CTX_W-1:0] ctx;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [GW-1:0]      req_gran;
    logic [CTX_W-1:0]   req_ctx;
    logic [ENTRIES-1:0] addr_hit, ctx_hit, oldest;
    logic               alloc_en;
    logic [IDX_W-1:0]   alloc_idx;
    req_kind_e          kind;

    assign req_gran = req_addr[ADDR_W-1:GRAN_BITS];
    assign req_ctx  = {req_cpu, req_thread};
    assign kind     = classify(req_valid, req_write, req_locked);

    resv_cmp #(.ENTRIES(ENTRIES), .GW(GW), .CTX_W(CTX_W)) u_cmp (
        .valid    (tbl_q.valid),
        .gran     (tbl_q.gran),
        .ctx      (tbl_q.ctx),
        .req_gran (req_gran),
        .req_ctx  (req_ctx),
        .addr_hit (addr_hit),
        .ctx_hit  (ctx_hit)
    );

    resv_age #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (tbl_q.valid),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .oldest    (oldest)
    );

    logic             own_hit;
    logic             free_any, ctx_any;
    logic [IDX_W-1:0] free_idx, ctx_idx, old_idx, tgt_idx;

    always_comb begin
        own_hit  = |(addr_hit & ctx_hit);
        free_any = 1'b0;
        ctx_any  = 1'b0;
        free_idx = '0;
        ctx_idx  = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!tbl_q.valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (ctx_hit[i]) begin
                ctx_any = 1'b1;
                ctx_idx = IDX_W'(i);
            end
            if (oldest[i]) old_idx = IDX_W'(i);
        end
        tgt_idx = free_any ? free_idx : old_idx;
    end

    always_comb begin
        tbl_d     = tbl_q;
        wr_en     = 1'b0;
        sc_ok     = 1'b0;
        alloc_en  = 1'b0;
        alloc_idx = tgt_idx;
        unique case (kind)
            RK_STORE: begin
                wr_en       = 1'b1;
                tbl_d.valid = tbl_q.valid & ~addr_hit;
            end
            RK_SC: begin
                wr_en       = own_hit;
                sc_ok       = own_hit;
                tbl_d.valid = tbl_q.valid & ~addr_hit;
            end
            RK_LL: begin
                if (ctx_any) begin
                    tbl_d.gran[ctx_idx] = req_gran;
                end else begin
                    alloc_en              = 1'b1;
                    tbl_d.valid[tgt_idx]  = 1'b1;
                    tbl_d.gran[tgt_idx]   = req_gran;
                    tbl_d.ctx[tgt_idx]    = req_ctx;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |-> (!wr_en && !sc_ok)); // R11

    AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_locked) |-> (wr_en && !sc_ok)); // R6

    AST_SC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_locked) |-> (wr_en == sc_ok)); // R7

    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |=> ($countones(tbl_q.valid) < $past($countones(tbl_q.valid)))); // R4

    AST_LL_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_locked) |=> (tbl_q.valid != '0)); // R3

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write) |=>
            !(tbl_q.valid[i] && tbl_q.gran[i] == $past(req_addr[ADDR_W-1:GRAN_BITS]))); // R5
        for (genvar j = i + 1; j < ENTRIES; j++) begin : g_pair
            AST_ONE_PER_CTX: assert property (@(posedge clk) disable iff (!rst_n)
                (tbl_q.valid[i] && tbl_q.valid[j]) |-> (tbl_q.ctx[i] != tbl_q.ctx[j])); // R3
        end
    end

endmodule

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_locked = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [0:0]  req_thread = '0;
    logic        wr_en, sc_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    resv_monitor u_resv_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_locked(req_locked), .req_addr(req_addr), .req_cpu(req_cpu),
        .req_thread(req_thread), .wr_en(wr_en), .sc_ok(sc_ok)
    );

    // behavioural table: one slot per record, age by allocation stamp
    bit          m_v[4];
    logic [27:0] m_g[4];
    int          m_c[4];
    int          m_s[4];
    int          stamp = 0;

    task automatic check(input bit act, input bit exp, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit model_own(input logic [27:0] g, input int c);
        for (int i = 0; i < 4; i++) if (m_v[i] && m_g[i] == g && m_c[i] == c) return 1;
        return 0;
    endfunction

    task automatic model_update(input bit w, input bit l, input logic [27:0] g, input int c);
        if (w) begin
            for (int i = 0; i < 4; i++) if (m_v[i] && m_g[i] == g) m_v[i] = 0;
        end else if (l) begin
            int slot = -1;
            for (int i = 0; i < 4; i++) if (m_v[i] && m_c[i] == c) slot = i;
            if (slot >= 0) begin
                m_g[slot] = g;
            end else begin
                for (int i = 3; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = 0;
                    for (int i = 1; i < 4; i++) if (m_s[i] < m_s[slot]) slot = i;
                end
                m_v[slot] = 1; m_g[slot] = g; m_c[slot] = c; m_s[slot] = stamp++;
            end
        end
    endtask

    // exp_sc: -1 = take expectation from the behavioural table
    task automatic op(input bit v, input bit w, input bit l, input logic [31:0] a,
                      input int c, input int exp_sc, input string tag);
        bit esc, ewe;
        @(negedge clk);
        req_valid = v; req_write = w; req_locked = l; req_addr = a;
        req_cpu = 2'(c >> 1); req_thread = 1'(c);
        #1;
        if (exp_sc < 0) esc = v && w && l && model_own(a[31:4], c);
        else            esc = exp_sc[0];
        ewe = v && w && (!l || esc);
        check(wr_en, ewe, "wr_en", tag);
        check(sc_ok, esc, "sc_ok", tag);
        if (v) model_update(w, l, a[31:4], c);
    endtask

    task automatic ll(input logic [31:0] a, input int c, input string tag);
        op(1, 0, 1, a, c, 0, tag);
    endtask
    task automatic sc(input logic [31:0] a, input int c, input int e, input string tag);
        op(1, 1, 1, a, c, e, tag);
    endtask
    task automatic st(input logic [31:0] a, input int c, input string tag);
        op(1, 1, 0, a, c, 0, tag);
    endtask
    task automatic flush();
        for (int k = 0; k < 8; k++) st(32'h1000 + k * 16, 0, "R5");
        for (int k = 1; k < 4; k++) st(32'h100 * k, 0, "R5");
        for (int k = 1; k < 4; k++) st(32'h100 * k + 16, 0, "R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 4; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        op(0, 0, 0, 32'h0, 0, 0, "R1");
        for (int c = 0; c < 8; c++) sc(32'h1000 + c * 16, c, 0, "R1");
        st(32'h1000, 3, "R1");

        // R10 / R11: reads and idle do not disturb a reservation
        ll(32'h1000, 2, "R11");
        op(1, 0, 0, 32'h1000, 2, 0, "R10");
        op(1, 0, 0, 32'h1004, 5, 0, "R10");
        op(0, 1, 1, 32'h1000, 5, 0, "R10");
        op(0, 1, 0, 32'h1000, 5, 0, "R11");
        sc(32'h100c, 2, 1, "R10");

        // R2: every offset of the granule hits, the next granule misses
        for (int c = 0; c < 8; c++) begin
            for (int off = 0; off < 16; off++) begin
                ll(32'h200 + ((off * 7) & 15), c, "R2");
                sc(32'h200 + off, c, 1, "R2");
            end
            ll(32'h200, c, "R2");
            sc(32'h210, c, 0, "R2");
            st(32'h200, c, "R6");
            sc(32'h20f, c, 0, "R2");
        end
        flush();

        // R3: moving a reservation
        ll(32'h1000, 1, "R3");
        ll(32'h1010, 1, "R3");
        sc(32'h1000, 1, 0, "R3");
        sc(32'h1018, 1, 1, "R3");

        // R8: shared granule
        ll(32'h1020, 0, "R8");
        ll(32'h1024, 6, "R8");
        sc(32'h1028, 6, 1, "R8");
        sc(32'h1020, 0, 0, "R8");

        // R5: ordinary store and failed conditional both clear all owners
        ll(32'h1030, 0, "R5");
        ll(32'h1030, 1, "R5");
        st(32'h1033, 4, "R6");
        sc(32'h1030, 0, 0, "R5");
        sc(32'h1030, 1, 0, "R5");
        ll(32'h1040, 2, "R5");
        sc(32'h1040, 7, 0, "R7");
        sc(32'h1040, 2, 0, "R5");
        flush();

        // R9: eviction of the earliest allocation, moves do not refresh age
        ll(32'h1000, 0, "R9");
        ll(32'h1010, 1, "R9");
        ll(32'h1020, 2, "R9");
        ll(32'h1030, 3, "R9");
        ll(32'h1004, 0, "R9");
        ll(32'h1040, 4, "R9");
        sc(32'h1000, 0, 0, "R9");
        sc(32'h1010, 1, 1, "R9");
        sc(32'h1020, 2, 1, "R9");
        sc(32'h1030, 3, 1, "R9");
        sc(32'h1040, 4, 1, "R9");
        ll(32'h1050, 5, "R9");
        ll(32'h1060, 6, "R9");
        ll(32'h1070, 7, "R9");
        ll(32'h1000, 0, "R9");
        ll(32'h1010, 1, "R9");
        sc(32'h1050, 5, 0, "R9");
        sc(32'h1060, 6, 1, "R9");
        sc(32'h1010, 1, 1, "R9");
        flush();

        // R4: pseudo-random mix against the behavioural table
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            int c, kind;
            logic [31:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c    = int'(lfsr[2:0]);
            a    = 32'h100 * (int'(lfsr[4:3]) % 3 + 1) + 32'(lfsr[8:5]) + (lfsr[9] ? 32'h10 : 32'h0);
            kind = int'(lfsr[12:11]);
            case (kind)
                0, 3: op(1, 0, 1, a, c, -1, "R4");
                1:    op(1, 1, 1, a, c, -1, "R4");
                default: op(1, lfsr[13], 0, a, c, -1, "R4");
            endcase
        end

        @(negedge clk) req_valid = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule